// File: doc/BRIEF.md
# Queue Channel Control Register Block

This block holds the software-visible registers and the control state for a set of DMA copy channels that work from rings in memory. Each channel has a submission ring and a completion ring. For each ring the block keeps a 64-bit base and a depth. Software moves the submission tail (the doorbell) and the completion head. The block also keeps the hardware-side submission head and completion tail. A host issues single 32-bit reads and writes on a simple request bus. Every channel owns a window of 256 bytes, and the channel index sits in the address bits above that window.

A separate copy engine watches `eng_active`, the ring bases and the pointers of each channel. It reports the end of each descriptor with a done pulse or an error pulse, and the error pulse carries a class. The block advances the hardware pointers and raises interrupt status. It moves a readable per-channel state machine through idle, run, completion, pause, halt, abort, wait and buffer-clear. Software can pause, disable or soft-reset a channel. A soft reset returns the channel to idle with every ring pointer at zero.

Top module: `qchan_ctl`

## Requirements
- R1: Channel c owns addresses c*0x100 to c*0x100+0xFF. The offsets are: submission base low/high 0x00/0x04, submission depth 0x08, submission tail 0x0C, completion base low/high 0x10/0x14, completion depth 0x18, completion head 0x1C, control 0x20, reset 0x24, state 0x30, hardware submission head 0x34, hardware completion tail 0x3C, status 0x40, mask 0x44, and error counters 0x84/0x88/0x8C. A write changes only the addressed channel. Offsets not listed here, and channel indices at or above NUM_CH, read as zero.
- R2: A read request returns its data on `rd_data`, with `rd_valid` high, on the cycle after the request.
- R3: A depth register holds the ring entry count minus one. The hardware submission head and the completion tail advance by one per finished descriptor and wrap to 0 after reaching the depth value.
- R4: The state register reads a 4-bit code: 0 idle, 1 run, 2 completion, 3 paused, 4 halted, 5 aborted, 6 wait, 7 buffer-clear. The state is 0 after reset. Idle moves to run only when control bit 0 (enable) is 1, control bit 4 (pause) is 0 and the submission tail differs from the hardware head.
- R5: In run, pause=1 moves the channel to paused and enable=0 moves it to halted. Clearing pause moves it to halted if enable is 0, to run if work remains, and to idle otherwise. Halted moves to idle once enable=1 and pause=0.
- R6: A done pulse in run advances the pointers and sets status bit 0. The channel then spends one cycle in completion, after which it goes to run if the idle-to-run condition holds and to idle otherwise.
- R7: An error pulse in run advances the pointers and sets status bit 1. With control bit 2 (error abort) at 1 the channel enters aborted and stays there until a soft reset. With bit 2 at 0 it spends one cycle in wait and then continues as after a completion.
- R8: Writing 1 to bit 0 at offset 0x24 makes that bit read 1 for exactly one cycle. The channel then spends one cycle in buffer-clear, with the submission tail, the completion head, the hardware head and the hardware completion tail all at 0, and then returns to idle.
- R9: `irq[c]` is high while any status bit has a 0 in the matching mask bit. Writing 1 to a status bit clears it, but a set in the same cycle wins.
- R10: The error counters at 0x84, 0x88 and 0x8C count error pulses of class 0, class 1 and class 2 or 3. Each counter saturates at its all-ones value, and a host write loads it directly.
- R11: Done and error pulses that arrive while the channel is not in run are ignored. The pointers, status and counters stay as they were.
- R12: `eng_active[c]` is high exactly while channel c is in run. The engine outputs carry the channel's ring bases, tail and hardware head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: channel index above bit 7, offset below |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| eng_done | input | NUM_CH | Per-channel descriptor finished without error |
| eng_err | input | NUM_CH | Per-channel descriptor finished with error |
| eng_err_cls | input | 2*NUM_CH | Per-channel error class |
| eng_active | output | NUM_CH | Channel is in run |
| eng_sq_tail | output | NUM_CH*PTR_W | Submission tail per channel |
| eng_sq_head | output | NUM_CH*PTR_W | Hardware submission head per channel |
| eng_sq_base | output | NUM_CH*64 | Submission ring base per channel |
| eng_cq_base | output | NUM_CH*64 | Completion ring base per channel |
| irq | output | NUM_CH | Per-channel unmasked interrupt |

## Verification
The bench targets the wrap of the hardware head at the depth value. A design off by one there would walk past the ring end or wrap one entry early. It issues a read on the cycle right after a soft-reset write: a reset bit that does not self-clear, or a missing buffer-clear cycle, shows up as a wrong read value. It pulses completion events while the channel is halted or aborted, which exposes a design that moves pointers outside run. It clears a status bit on the same cycle as a new completion, to catch clear-wins priority. It pushes an error counter to all ones, to catch wrap-around. It also drives each pause and enable transition out of run and checks which state each one lands in.

// File: rtl/qchan_pkg.sv
package qchan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_RUN    = 4'd1,
        ST_CPL    = 4'd2,
        ST_PAUSE  = 4'd3,
        ST_HALT   = 4'd4,
        ST_ABORT  = 4'd5,
        ST_WAIT   = 4'd6,
        ST_BUFCLR = 4'd7
    } qstate_e;

    localparam logic [7:0] OFF_SQ_LO   = 8'h00;
    localparam logic [7:0] OFF_SQ_HI   = 8'h04;
    localparam logic [7:0] OFF_SQ_DEP  = 8'h08;
    localparam logic [7:0] OFF_SQ_TAIL = 8'h0C;
    localparam logic [7:0] OFF_CQ_LO   = 8'h10;
    localparam logic [7:0] OFF_CQ_HI   = 8'h14;
    localparam logic [7:0] OFF_CQ_DEP  = 8'h18;
    localparam logic [7:0] OFF_CQ_HEAD = 8'h1C;
    localparam logic [7:0] OFF_CTL0    = 8'h20;
    localparam logic [7:0] OFF_CTL1    = 8'h24;
    localparam logic [7:0] OFF_STATE   = 8'h30;
    localparam logic [7:0] OFF_HW_HEAD = 8'h34;
    localparam logic [7:0] OFF_HW_CTL  = 8'h3C;
    localparam logic [7:0] OFF_STS     = 8'h40;
    localparam logic [7:0] OFF_MSK     = 8'h44;
    localparam logic [7:0] OFF_CNT0    = 8'h84;

    localparam int STS_W  = 2;
    localparam int CTR_N  = 3;
    localparam int WIN_W  = 8;

    typedef struct packed {
        logic pause;
        logic abort_en;
        logic en;
    } ctrl_t;

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        return {27'd0, c.pause, 1'b0, c.abort_en, 1'b0, c.en};
    endfunction

    function automatic int err_slot(logic [1:0] cls);
        return (cls == 2'd0) ? 0 : (cls == 2'd1) ? 1 : 2;
    endfunction

endpackage

// File: rtl/qchan_decode.sv
module qchan_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic [NUM_CH-1:0]         wr_sel,
    output logic                      hit,
    output logic [ADDR_W-qchan_pkg::WIN_W-1:0] ch_idx,
    output logic [qchan_pkg::WIN_W-1:0]        offset
);
    localparam int CI_W = ADDR_W - qchan_pkg::WIN_W;

    assign ch_idx = req_addr[ADDR_W-1:qchan_pkg::WIN_W];
    assign offset = req_addr[qchan_pkg::WIN_W-1:0];
    assign hit    = ({1'b0, ch_idx} < (CI_W+1)'(NUM_CH));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_sel[i] = req_valid && req_write && hit && (ch_idx == CI_W'(i));
    end
endmodule

// File: rtl/qchan_rdmux.sv
module qchan_rdmux #(
    parameter int NUM_CH = 4,
    parameter int CI_W   = 4
) (
    input  logic [NUM_CH*32-1:0] words,
    input  logic [CI_W-1:0]      sel,
    input  logic                 hit,
    output logic [31:0]          word
);
    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit && sel == CI_W'(i)) word = words[i*32 +: 32];
        end
    end
endmodule

// File: rtl/qchan_channel.sv
module qchan_channel
    import qchan_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int CTR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIN_W-1:0]  off,
    input  logic [31:0]       wdata,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [1:0]        eng_cls,
    output logic [31:0]       rd_word,
    output qstate_e           state,
    output logic              rst_pend,
    output logic              active,
    output logic              irq,
    output logic [PTR_W-1:0]  sq_head,
    output logic [PTR_W-1:0]  sq_tail_o,
    output logic [63:0]       sq_base,
    output logic [63:0]       cq_base
);
    logic [31:0]      sq_lo, sq_hi, cq_lo, cq_hi;
    logic [PTR_W-1:0] sq_dep, cq_dep, sq_tail, cq_head, hw_head, hw_ctail;
    logic [PTR_W-1:0] head_nx, ctail_nx;
    ctrl_t            ctl;
    qstate_e          st, st_nx;
    logic [STS_W-1:0] sts, msk, sts_set, sts_clr;
    logic [CTR_W-1:0] cnt [CTR_N];
    logic             work, go, ev_ok, ev_err, ev_done;

    assign work    = (sq_tail != hw_head);
    assign go      = ctl.en && !ctl.pause && work;
    assign ev_ok   = (st == ST_RUN) && !rst_pend;
    assign ev_err  = ev_ok && eng_err;
    assign ev_done = ev_ok && eng_done && !eng_err;
    assign head_nx  = (hw_head  == sq_dep) ? '0 : hw_head  + 1'b1;
    assign ctail_nx = (hw_ctail == cq_dep) ? '0 : hw_ctail + 1'b1;
    assign sts_set = {ev_err, ev_done};
    assign sts_clr = (wr_en && off == OFF_STS) ? wdata[STS_W-1:0] : '0;

    always_comb begin
        st_nx = st;
        if (rst_pend) begin
            st_nx = ST_BUFCLR;
        end else begin
            case (st)
                ST_IDLE:  if (go) st_nx = ST_RUN;
                ST_RUN: begin
                    if (ev_err)          st_nx = ctl.abort_en ? ST_ABORT : ST_WAIT;
                    else if (ev_done)    st_nx = ST_CPL;
                    else if (ctl.pause)  st_nx = ST_PAUSE;
                    else if (!ctl.en)    st_nx = ST_HALT;
                end
                ST_CPL, ST_WAIT: st_nx = go ? ST_RUN : ST_IDLE;
                ST_PAUSE: if (!ctl.pause) st_nx = !ctl.en ? ST_HALT : (work ? ST_RUN : ST_IDLE);
                ST_HALT:  if (ctl.en && !ctl.pause) st_nx = ST_IDLE;
                ST_ABORT: st_nx = ST_ABORT;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            rst_pend <= 1'b0;
            ctl      <= '0;
            sq_lo    <= '0;
            sq_hi    <= '0;
            cq_lo    <= '0;
            cq_hi    <= '0;
            sq_dep   <= '0;
            cq_dep   <= '0;
            sq_tail  <= '0;
            cq_head  <= '0;
            hw_head  <= '0;
            hw_ctail <= '0;
            sts      <= '0;
            msk      <= '0;
            for (int k = 0; k < CTR_N; k++) cnt[k] <= '0;
        end else begin
            st       <= st_nx;
            rst_pend <= wr_en && off == OFF_CTL1 && wdata[0];
            if (wr_en && off == OFF_CTL0)
                ctl <= '{pause: wdata[4], abort_en: wdata[2], en: wdata[0]};
            if (wr_en && off == OFF_SQ_LO)  sq_lo  <= wdata;
            if (wr_en && off == OFF_SQ_HI)  sq_hi  <= wdata;
            if (wr_en && off == OFF_CQ_LO)  cq_lo  <= wdata;
            if (wr_en && off == OFF_CQ_HI)  cq_hi  <= wdata;
            if (wr_en && off == OFF_SQ_DEP) sq_dep <= wdata[PTR_W-1:0];
            if (wr_en && off == OFF_CQ_DEP) cq_dep <= wdata[PTR_W-1:0];
            if (rst_pend) begin
                sq_tail  <= '0;
                cq_head  <= '0;
                hw_head  <= '0;
                hw_ctail <= '0;
            end else begin
                if (wr_en && off == OFF_SQ_TAIL) sq_tail <= wdata[PTR_W-1:0];
                if (wr_en && off == OFF_CQ_HEAD) cq_head <= wdata[PTR_W-1:0];
                if (ev_err || ev_done) begin
                    hw_head  <= head_nx;
                    hw_ctail <= ctail_nx;
                end
            end
            sts <= (sts & ~sts_clr) | sts_set;
            if (wr_en && off == OFF_MSK) msk <= wdata[STS_W-1:0];
            for (int k = 0; k < CTR_N; k++) begin
                if (wr_en && off == OFF_CNT0 + 8'(4*k))
                    cnt[k] <= wdata[CTR_W-1:0];
                else if (ev_err && err_slot(eng_cls) == k && cnt[k] != '1)
                    cnt[k] <= cnt[k] + 1'b1;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (off)
            OFF_SQ_LO:   rd_word = sq_lo;
            OFF_SQ_HI:   rd_word = sq_hi;
            OFF_SQ_DEP:  rd_word = 32'(sq_dep);
            OFF_SQ_TAIL: rd_word = 32'(sq_tail);
            OFF_CQ_LO:   rd_word = cq_lo;
            OFF_CQ_HI:   rd_word = cq_hi;
            OFF_CQ_DEP:  rd_word = 32'(cq_dep);
            OFF_CQ_HEAD: rd_word = 32'(cq_head);
            OFF_CTL0:    rd_word = ctrl_word(ctl);
            OFF_CTL1:    rd_word = {31'd0, rst_pend};
            OFF_STATE:   rd_word = 32'(st);
            OFF_HW_HEAD: rd_word = 32'(hw_head);
            OFF_HW_CTL:  rd_word = 32'(hw_ctail);
            OFF_STS:     rd_word = 32'(sts);
            OFF_MSK:     rd_word = 32'(msk);
            8'h84:       rd_word = 32'(cnt[0]);
            8'h88:       rd_word = 32'(cnt[1]);
            8'h8C:       rd_word = 32'(cnt[2]);
            default:     rd_word = '0;
        endcase
    end

    assign state     = st;
    assign active    = (st == ST_RUN);
    assign irq       = |(sts & ~msk);
    assign sq_head   = hw_head;
    assign sq_tail_o = sq_tail;
    assign sq_base   = {sq_hi, sq_lo};
    assign cq_base   = {cq_hi, cq_lo};
endmodule

// File: rtl/qchan_ctl.sv
module qchan_ctl
    import qchan_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12,
    parameter int PTR_W  = 10,
    parameter int CTR_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [31:0]             req_wdata,
    output logic                    rd_valid,
    output logic [31:0]             rd_data,
    input  logic [NUM_CH-1:0]       eng_done,
    input  logic [NUM_CH-1:0]       eng_err,
    input  logic [2*NUM_CH-1:0]     eng_err_cls,
    output logic [NUM_CH-1:0]       eng_active,
    output logic [NUM_CH*PTR_W-1:0] eng_sq_tail,
    output logic [NUM_CH*PTR_W-1:0] eng_sq_head,
    output logic [NUM_CH*64-1:0]    eng_sq_base,
    output logic [NUM_CH*64-1:0]    eng_cq_base,
    output logic [NUM_CH-1:0]       irq
);
    localparam int CI_W = ADDR_W - WIN_W;

    logic [NUM_CH-1:0]    wr_sel;
    logic                 hit;
    logic [CI_W-1:0]      ch_idx;
    logic [WIN_W-1:0]     offset;
    logic [NUM_CH*32-1:0] words;
    logic [31:0]          rd_mux;
    logic [NUM_CH*4-1:0]  st_flat;
    logic [NUM_CH-1:0]    rp_flat;

    qchan_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_sel    (wr_sel),
        .hit       (hit),
        .ch_idx    (ch_idx),
        .offset    (offset)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        qstate_e ch_st;
        qchan_channel #(.PTR_W(PTR_W), .CTR_W(CTR_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_sel[i]),
            .off       (offset),
            .wdata     (req_wdata),
            .eng_done  (eng_done[i]),
            .eng_err   (eng_err[i]),
            .eng_cls   (eng_err_cls[2*i +: 2]),
            .rd_word   (words[32*i +: 32]),
            .state     (ch_st),
            .rst_pend  (rp_flat[i]),
            .active    (eng_active[i]),
            .irq       (irq[i]),
            .sq_head   (eng_sq_head[PTR_W*i +: PTR_W]),
            .sq_tail_o (eng_sq_tail[PTR_W*i +: PTR_W]),
            .sq_base   (eng_sq_base[64*i +: 64]),
            .cq_base   (eng_cq_base[64*i +: 64])
        );
        assign st_flat[4*i +: 4] = ch_st;
    end

    qchan_rdmux #(.NUM_CH(NUM_CH), .CI_W(CI_W)) u_mux (
        .words (words),
        .sel   (ch_idx),
        .hit   (hit),
        .word  (rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/qchan_ctl_chk.sv
module qchan_ctl_chk #(
    parameter int NUM_CH = 4,
    parameter int PTR_W  = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH-1:0]       eng_active,
    input logic [NUM_CH-1:0]       eng_done,
    input logic [NUM_CH-1:0]       eng_err,
    input logic [NUM_CH*PTR_W-1:0] eng_sq_head,
    input logic [NUM_CH*4-1:0]     st_flat,
    input logic [NUM_CH-1:0]       rp_flat
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R8
        bufclr_enter_chk: assert property (@(posedge clk) disable iff (rst)
            rp_flat[i] |=> (st_flat[4*i +: 4] == 4'd7 && eng_sq_head[PTR_W*i +: PTR_W] == '0));
        // R8
        bufclr_exit_chk: assert property (@(posedge clk) disable iff (rst)
            (st_flat[4*i +: 4] == 4'd7 && !rp_flat[i]) |=> st_flat[4*i +: 4] == 4'd0);
        // R11
        head_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!eng_active[i] && !rp_flat[i]) |=> $stable(eng_sq_head[PTR_W*i +: PTR_W]));
        // R6
        cpl_enter_chk: assert property (@(posedge clk) disable iff (rst)
            (eng_active[i] && eng_done[i] && !eng_err[i] && !rp_flat[i]) |=> st_flat[4*i +: 4] == 4'd2);
        // R7
        abort_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (st_flat[4*i +: 4] == 4'd5 && !rp_flat[i]) |=> st_flat[4*i +: 4] == 4'd5);
    end
endmodule

bind qchan_ctl qchan_ctl_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eng_active  (eng_active),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .eng_sq_head (eng_sq_head),
    .st_flat     (st_flat),
    .rp_flat     (rp_flat)
);

// File: tb/tb_qchan_ctl.sv
`timescale 1ns/1ps
module tb_qchan_ctl;
    localparam int NCH = 4;
    localparam int PW  = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]      req_addr = '0;
    logic [31:0]      req_wdata = '0;
    logic             rd_valid;
    logic [31:0]      rd_data;
    logic [NCH-1:0]   eng_done = '0, eng_err = '0;
    logic [2*NCH-1:0] eng_err_cls = '0;
    logic [NCH-1:0]   eng_active, irq;
    logic [NCH*PW-1:0] eng_sq_tail, eng_sq_head;
    logic [NCH*64-1:0] eng_sq_base, eng_cq_base;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    qchan_ctl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .eng_done(eng_done), .eng_err(eng_err), .eng_err_cls(eng_err_cls),
        .eng_active(eng_active), .eng_sq_tail(eng_sq_tail), .eng_sq_head(eng_sq_head),
        .eng_sq_base(eng_sq_base), .eng_cq_base(eng_cq_base), .irq(irq)
    );

    // behavioural reference model
    int m_st[NCH], m_en[NCH], m_pa[NCH], m_ab[NCH], m_rp[NCH];
    int m_head[NCH], m_ctl[NCH], m_tail[NCH], m_cqh[NCH], m_sqd[NCH], m_cqd[NCH];
    int m_sts[NCH], m_msk[NCH];
    int m_cnt[NCH][3];
    logic [31:0] m_b[NCH][4];
    bit          exp_rdv;
    logic [31:0] exp_rd;

    function automatic logic [31:0] mread(logic [11:0] a);
        int c = int'(a[11:8]);
        int o = int'(a[7:0]);
        if (c >= NCH) return 0;
        case (o)
            'h00: return m_b[c][0];
            'h04: return m_b[c][1];
            'h10: return m_b[c][2];
            'h14: return m_b[c][3];
            'h08: return m_sqd[c];
            'h0C: return m_tail[c];
            'h18: return m_cqd[c];
            'h1C: return m_cqh[c];
            'h20: return m_en[c] + 4*m_ab[c] + 16*m_pa[c];
            'h24: return m_rp[c];
            'h30: return m_st[c];
            'h34: return m_head[c];
            'h3C: return m_ctl[c];
            'h40: return m_sts[c];
            'h44: return m_msk[c];
            'h84: return m_cnt[c][0];
            'h88: return m_cnt[c][1];
            'h8C: return m_cnt[c][2];
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_rdv = 0;
            exp_rd  = 0;
            for (int c = 0; c < NCH; c++) begin
                m_st[c] = 0; m_en[c] = 0; m_pa[c] = 0; m_ab[c] = 0; m_rp[c] = 0;
                m_head[c] = 0; m_ctl[c] = 0; m_tail[c] = 0; m_cqh[c] = 0;
                m_sqd[c] = 0; m_cqd[c] = 0; m_sts[c] = 0; m_msk[c] = 0;
                for (int k = 0; k < 4; k++) m_b[c][k] = 0;
                for (int k = 0; k < 3; k++) m_cnt[c][k] = 0;
            end
        end else begin
            exp_rdv = req_valid && !req_write;
            exp_rd  = exp_rdv ? mread(req_addr) : 0;
            for (int c = 0; c < NCH; c++) begin
                bit wr, go, ok, er, dn;
                int o, d, nst, slot;
                wr = req_valid && req_write && int'(req_addr[11:8]) == c;
                o  = int'(req_addr[7:0]);
                d  = int'(req_wdata);
                go = m_en[c] && !m_pa[c] && (m_tail[c] != m_head[c]);
                ok = (m_st[c] == 1) && !m_rp[c];
                er = ok && eng_err[c];
                dn = ok && eng_done[c] && !eng_err[c];
                slot = (eng_err_cls[2*c +: 2] == 0) ? 0 : (eng_err_cls[2*c +: 2] == 1) ? 1 : 2;
                nst = m_st[c];
                if (m_rp[c]) nst = 7;
                else case (m_st[c])
                    0: nst = go ? 1 : 0;
                    1: nst = er ? (m_ab[c] ? 5 : 6) : dn ? 2 : m_pa[c] ? 3 : !m_en[c] ? 4 : 1;
                    2, 6: nst = go ? 1 : 0;
                    3: nst = m_pa[c] ? 3 : !m_en[c] ? 4 : (m_tail[c] != m_head[c]) ? 1 : 0;
                    4: nst = (m_en[c] && !m_pa[c]) ? 0 : 4;
                    5: nst = 5;
                    default: nst = 0;
                endcase
                if (m_rp[c]) begin
                    m_tail[c] = 0; m_cqh[c] = 0; m_head[c] = 0; m_ctl[c] = 0;
                end else begin
                    if (wr && o == 'h0C) m_tail[c] = d % 1024;
                    if (wr && o == 'h1C) m_cqh[c] = d % 1024;
                    if (er || dn) begin
                        m_head[c] = (m_head[c] == m_sqd[c]) ? 0 : m_head[c] + 1;
                        m_ctl[c]  = (m_ctl[c]  == m_cqd[c]) ? 0 : m_ctl[c] + 1;
                    end
                end
                m_st[c] = nst;
                m_rp[c] = (wr && o == 'h24 && d[0]) ? 1 : 0;
                if (wr && o == 'h20) begin m_en[c] = d[0]; m_ab[c] = d[2]; m_pa[c] = d[4]; end
                if (wr && o == 'h00) m_b[c][0] = d;
                if (wr && o == 'h04) m_b[c][1] = d;
                if (wr && o == 'h10) m_b[c][2] = d;
                if (wr && o == 'h14) m_b[c][3] = d;
                if (wr && o == 'h08) m_sqd[c] = d % 1024;
                if (wr && o == 'h18) m_cqd[c] = d % 1024;
                m_sts[c] = (m_sts[c] & ~((wr && o == 'h40) ? (d & 3) : 0)) | (dn ? 1 : 0) | (er ? 2 : 0);
                if (wr && o == 'h44) m_msk[c] = d & 3;
                for (int k = 0; k < 3; k++) begin
                    if (wr && o == 'h84 + 4*k) m_cnt[c][k] = d & 'hFFFF;
                    else if (er && slot == k && m_cnt[c][k] != 'hFFFF) m_cnt[c][k]++;
                end
            end
        end
    end

    task automatic chk(string req, longint got, longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 rd_valid", rd_valid, exp_rdv);
            if (exp_rdv) chk("R2 rd_data", rd_data, exp_rd);
            for (int c = 0; c < NCH; c++) begin
                chk("R12 eng_active", eng_active[c], m_st[c] == 1);
                chk("R9 irq", irq[c], (m_sts[c] & ~m_msk[c]) != 0);
                chk("R12 sq head", eng_sq_head[PW*c +: PW], m_head[c]);
                chk("R12 sq tail", eng_sq_tail[PW*c +: PW], m_tail[c]);
            end
        end
    end

    // stimulus tasks: entered at a negedge, leave at a negedge
    task automatic wr(int c, int o, logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = 12'(c*256 + o); req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd_now(int c, int o, logic [31:0] e, string req);
        req_valid = 1; req_write = 0; req_addr = 12'(c*256 + o);
        @(negedge clk);
        req_valid = 0;
        chk(req, rd_data, e);
    endtask

    task automatic rd_exp(int c, int o, logic [31:0] e, string req);
        repeat (2) @(negedge clk);
        rd_now(c, o, e, req);
    endtask

    task automatic ev(int c, bit dn, bit er, int cls);
        repeat (2) @(negedge clk);
        eng_done[c] = dn; eng_err[c] = er; eng_err_cls[2*c +: 2] = 2'(cls);
        @(negedge clk);
        eng_done = '0; eng_err = '0; eng_err_cls = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        rd_now(0, 'h30, 0, "R4 reset state");
        rd_now(0, 'h24, 0, "R8 reset bit idle");

        // R1 decode
        wr(1, 'h00, 32'hA5A5_0000);
        wr(1, 'h04, 32'h0000_1234);
        rd_now(1, 'h00, 32'hA5A5_0000, "R1 base low");
        rd_now(0, 'h00, 0, "R1 other channel untouched");
        rd_now(9, 'h00, 0, "R1 channel out of range");
        rd_now(1, 'h28, 0, "R1 unimplemented offset");
        chk("R12 sq base", eng_sq_base[127:64], 64'h0000_1234_A5A5_0000);

        // R4 idle to run
        wr(0, 'h08, 3);
        wr(0, 'h18, 3);
        wr(0, 'h0C, 1);
        rd_exp(0, 'h30, 0, "R4 disabled stays idle");
        wr(0, 'h20, 'h11);
        rd_exp(0, 'h30, 0, "R4 paused stays idle");
        wr(0, 'h20, 'h01);
        rd_exp(0, 'h30, 1, "R4 run");

        // R6 completion
        ev(0, 1, 0, 0);
        rd_exp(0, 'h30, 0, "R6 back to idle");
        rd_exp(0, 'h34, 1, "R6 head advanced");
        rd_exp(0, 'h40, 1, "R6 status bit0");

        // R3 wrap
        wr(0, 'h0C, 3);
        ev(0, 1, 0, 0);
        ev(0, 1, 0, 0);
        rd_exp(0, 'h34, 3, "R3 head at depth");
        wr(0, 'h0C, 0);
        ev(0, 1, 0, 0);
        rd_exp(0, 'h34, 0, "R3 head wrapped");
        rd_exp(0, 'h3C, 0, "R3 completion tail wrapped");

        // R9 set wins over clear
        wr(0, 'h0C, 1);
        repeat (2) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h040; req_wdata = 1; eng_done[0] = 1;
        @(negedge clk);
        req_valid = 0; req_write = 0; eng_done = '0;
        rd_exp(0, 'h40, 1, "R9 set wins");
        wr(0, 'h40, 1);
        rd_exp(0, 'h40, 0, "R9 w1c");
        chk("R9 irq low after clear", irq[0], 0);

        // R5 pause / halt, R11 ignore
        wr(1, 'h08, 7);
        wr(1, 'h0C, 5);
        wr(1, 'h20, 'h01);
        rd_exp(1, 'h30, 1, "R5 run");
        wr(1, 'h20, 'h11);
        rd_exp(1, 'h30, 3, "R5 paused");
        wr(1, 'h20, 'h01);
        rd_exp(1, 'h30, 1, "R5 resume");
        wr(1, 'h20, 'h00);
        rd_exp(1, 'h30, 4, "R5 halted");
        ev(1, 1, 0, 0);
        rd_exp(1, 'h34, 0, "R11 halted ignores done");
        rd_exp(1, 'h40, 0, "R11 status untouched");
        wr(1, 'h20, 'h01);
        rd_exp(1, 'h30, 1, "R5 halt to idle to run");

        // R7 errors
        wr(2, 'h08, 1023);
        wr(2, 'h0C, 2);
        wr(2, 'h20, 'h01);
        ev(2, 0, 1, 1);
        rd_exp(2, 'h30, 1, "R7 wait then continue");
        rd_exp(2, 'h88, 1, "R10 class1 counter");
        rd_exp(2, 'h40, 2, "R7 status bit1");
        wr(2, 'h44, 3);
        rd_exp(2, 'h44, 3, "R9 mask");
        chk("R9 masked irq", irq[2], 0);
        wr(2, 'h44, 0);
        @(negedge clk);
        chk("R9 unmasked irq", irq[2], 1);
        wr(2, 'h20, 'h05);
        ev(2, 0, 1, 3);
        rd_exp(2, 'h30, 5, "R7 abort");
        rd_exp(2, 'h8C, 1, "R10 class3 counter");
        ev(2, 1, 0, 0);
        rd_exp(2, 'h30, 5, "R7 abort holds");
        rd_exp(2, 'h34, 2, "R11 aborted ignores done");

        // R8 soft reset
        wr(2, 'h24, 1);
        rd_now(2, 'h24, 1, "R8 reset bit one cycle");
        rd_now(2, 'h30, 7, "R8 buffer clear");
        rd_now(2, 'h30, 0, "R8 idle after clear");
        rd_now(2, 'h0C, 0, "R8 tail zero");
        rd_now(2, 'h34, 0, "R8 head zero");
        rd_now(2, 'h24, 0, "R8 reset bit self-cleared");

        // R10 saturation
        wr(3, 'h08, 7);
        wr(3, 'h0C, 3);
        wr(3, 'h84, 'hFFFE);
        wr(3, 'h20, 'h01);
        ev(3, 0, 1, 0);
        ev(3, 0, 1, 0);
        ev(3, 0, 1, 0);
        rd_exp(3, 'h84, 'hFFFF, "R10 saturated");
        wr(3, 'h84, 0);
        rd_exp(3, 'h84, 0, "R10 cleared by write");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule